// File: doc/BRIEF.md
# Dual-Bank Prioritised Interrupt Controller

The controller gathers 32 level-sensitive interrupt lines and reports them through two independent banks: a normal-request bank that drives `irq_o` and a fast-request bank that drives `fiq_o`. Both banks share one conditioning stage. That stage holds a per-source polarity selection, a per-source choice between latched (sticky) and live capture, and a per-source 4-bit priority.

Each bank keeps its own copy of the following state:
- an enable mask, changed through separate set and clear registers;
- a sticky latch;
- a priority threshold;
- a register that returns the number of the winning source;
- an acknowledge register whose read clears the winner's latch.

Software reads the status word of a bank. While that word is nonzero, it reads the current-source register and services the source it names.

Access goes over a plain 32-bit word-addressed register bus. The bus has read and write strobes. Read data is returned one cycle after the read strobe.

Top module: `intc_dual_bank`

## Requirements
- R1: After reset, both enable masks are 0, the two thresholds read 0xF, the polarity word reads 0xFFFFFFFF, the sticky word reads 0, every priority reads 0, and `irq_o` and `fiq_o` are low.
- R2: Writing the enable-set word (bank word 0x02) sets the mask bits where the written data is 1. Writing the enable-clear word (bank word 0x03) clears the mask bits where the written data is 1. Data bits that are 0 leave the mask unchanged. Reading word 0x02 returns the mask.
- R3: Polarity word (word 0x80): a bit of 1 passes that source unchanged, and a bit of 0 inverts it. The raw word (bank word 0x01) returns the conditioned levels, with no enable or threshold masking.
- R4: Sticky word (word 0x81): a bit of 1 latches the conditioned assertion of that source in each bank until that bank acknowledges it. A bit of 0 makes the source follow its live level.
- R5: The status word (bank word 0x00) holds each source that is conditioned high, enabled in the bank, and has a priority value no greater than the bank threshold (bank word 0x0B, 4 bits).
- R6: The current word (bank word 0x08) returns the source with the smallest priority value among the status bits. A tie goes to the lowest source number. The word reads 0 when status is 0. Priorities are at words 0xC0+n.
- R7: Reading the acknowledge word (bank word 0x0A) returns the current source and clears that source's latch in that bank only. When status is 0, the read changes nothing.
- R8: The two banks are independent. Enabling, thresholding or acknowledging in one bank has no effect on what the other bank reports.
- R9: `irq_o` (bank 0, words 0x00-0x3F) and `fiq_o` (bank 1, words 0x40-0x7F) are registered. Each is high in the cycle after the cycle in which its bank status is nonzero.
- R10: Read data is valid in the cycle after the read strobe. Unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt source levels |
| bus_addr_i | input | 8 | Word address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the strobe |
| irq_o | output | 1 | Normal-bank request |
| fiq_o | output | 1 | Fast-bank request |

## Verification
An acknowledge read and a fresh source assertion can fall in the same cycle. The bench provokes this by reading the acknowledge word in the cycle where a second sticky source rises. It also provokes it by acknowledging while the acknowledged line is still held high. The expected outcome follows the latch rules: a line that is still asserted re-latches, and a new line survives an acknowledge aimed at another source. These outcomes are judged through the raw and current words and through the request pins, against a behavioural model updated at every edge.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned N_BANK = 2;

  // region field (top two address bits)
  localparam logic [1:0] REG_BANK0 = 2'b00;
  localparam logic [1:0] REG_BANK1 = 2'b01;
  localparam logic [1:0] REG_CFG   = 2'b10;
  localparam logic [1:0] REG_PRIO  = 2'b11;

  // word offsets inside a bank
  localparam int unsigned OFF_STATUS = 'h00;
  localparam int unsigned OFF_RAW    = 'h01;
  localparam int unsigned OFF_EN     = 'h02;
  localparam int unsigned OFF_DIS    = 'h03;
  localparam int unsigned OFF_CUR    = 'h08;
  localparam int unsigned OFF_ACK    = 'h0A;
  localparam int unsigned OFF_MAX    = 'h0B;

  // word offsets inside the config region
  localparam int unsigned OFF_POL = 'h00;
  localparam int unsigned OFF_STK = 'h01;
endpackage

// File: rtl/intc_src_cond.sv
module intc_src_cond #(
  parameter int unsigned N_SRC = 32
) (
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] pol_i,
  output logic [N_SRC-1:0] cond_o
);
  // pol=1 passes, pol=0 inverts
  assign cond_o = ~(src_i ^ pol_i);
endmodule

// File: rtl/intc_prio_arb.sv
module intc_prio_arb #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]             req_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic                         valid_o,
  output logic [IDX_W-1:0]             idx_o
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    best    = '1;
    for (int i = 0; i < int'(N_SRC); i++) begin
      // strict compare keeps the lower index on ties
      if (req_i[i] && (!valid_o || prio_i[i] < best)) begin
        valid_o = 1'b1;
        best    = prio_i[i];
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_SRC-1:0]             cond_i,
  input  logic [N_SRC-1:0]             sticky_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic                         en_set_i,
  input  logic                         en_clr_i,
  input  logic [N_SRC-1:0]             en_data_i,
  input  logic                         max_we_i,
  input  logic [PRIO_W-1:0]            max_data_i,
  input  logic                         ack_i,
  output logic [N_SRC-1:0]             raw_o,
  output logic [N_SRC-1:0]             status_o,
  output logic [N_SRC-1:0]             en_o,
  output logic [PRIO_W-1:0]            max_o,
  output logic [IDX_W-1:0]             cur_o,
  output logic                         req_o
);
  logic [N_SRC-1:0]  latch_q, latch_d, en_q, thr_ok, clr;
  logic [PRIO_W-1:0] max_q;
  logic              req_q, valid;

  assign raw_o = cond_i | (latch_q & sticky_i);

  for (genvar i = 0; i < int'(N_SRC); i++) begin : g_thr
    assign thr_ok[i] = (prio_i[i] <= max_q);
  end

  assign status_o = raw_o & en_q & thr_ok;

  intc_prio_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .req_i  (status_o),
    .prio_i (prio_i),
    .valid_o(valid),
    .idx_o  (cur_o)
  );

  assign clr     = (ack_i && valid) ? (N_SRC'(1) << cur_o) : '0;
  assign latch_d = ((latch_q & ~clr) | cond_i) & sticky_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      en_q    <= '0;
      max_q   <= '1;
      req_q   <= 1'b0;
    end else begin
      latch_q <= latch_d;
      req_q   <= valid;
      if (en_set_i) en_q <= en_q | en_data_i;
      else if (en_clr_i) en_q <= en_q & ~en_data_i;
      if (max_we_i) max_q <= max_data_i;
    end
  end

  assign en_o  = en_q;
  assign max_o = max_q;
  assign req_o = req_q;
endmodule

// File: rtl/intc_dual_bank.sv
module intc_dual_bank
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned AW     = 8,
  parameter int unsigned DW     = 32,
  localparam int unsigned IDX_W = $clog2(N_SRC),
  localparam int unsigned LW    = AW - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  logic [1:0]    region;
  logic [LW-1:0] loc;
  assign region = bus_addr_i[AW-1:AW-2];
  assign loc    = bus_addr_i[LW-1:0];

  logic [N_SRC-1:0]             pol_q, stk_q, cond;
  logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
  logic                         cfg_sel, stk_we, pol_we;

  logic [N_BANK-1:0][N_SRC-1:0]  bank_raw, bank_status, bank_en;
  logic [N_BANK-1:0][PRIO_W-1:0] bank_max;
  logic [N_BANK-1:0][IDX_W-1:0]  bank_cur;
  logic [N_BANK-1:0]             bank_req, bank_en_set, bank_en_clr, bank_max_we, bank_ack;

  assign cfg_sel = (region == REG_CFG);
  assign pol_we  = bus_wr_i && cfg_sel && (loc == LW'(OFF_POL));
  assign stk_we  = bus_wr_i && cfg_sel && (loc == LW'(OFF_STK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q <= '1;
      stk_q <= '0;
    end else begin
      if (pol_we) pol_q <= bus_wdata_i[N_SRC-1:0];
      if (stk_we) stk_q <= bus_wdata_i[N_SRC-1:0];
    end
  end

  for (genvar i = 0; i < int'(N_SRC); i++) begin : g_prio
    logic we;
    assign we = bus_wr_i && (region == REG_PRIO) && (loc == LW'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  prio_q[i] <= '0;
      else if (we)  prio_q[i] <= bus_wdata_i[PRIO_W-1:0];
    end
  end

  intc_src_cond #(.N_SRC(N_SRC)) u_cond (
    .src_i (src_i),
    .pol_i (pol_q),
    .cond_o(cond)
  );

  for (genvar b = 0; b < int'(N_BANK); b++) begin : g_bank
    logic sel;
    assign sel            = (region == 2'(b));
    assign bank_en_set[b] = bus_wr_i && sel && (loc == LW'(OFF_EN));
    assign bank_en_clr[b] = bus_wr_i && sel && (loc == LW'(OFF_DIS));
    assign bank_max_we[b] = bus_wr_i && sel && (loc == LW'(OFF_MAX));
    assign bank_ack[b]    = bus_rd_i && sel && (loc == LW'(OFF_ACK));

    intc_bank #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cond_i    (cond),
      .sticky_i  (stk_q),
      .prio_i    (prio_q),
      .en_set_i  (bank_en_set[b]),
      .en_clr_i  (bank_en_clr[b]),
      .en_data_i (bus_wdata_i[N_SRC-1:0]),
      .max_we_i  (bank_max_we[b]),
      .max_data_i(bus_wdata_i[PRIO_W-1:0]),
      .ack_i     (bank_ack[b]),
      .raw_o     (bank_raw[b]),
      .status_o  (bank_status[b]),
      .en_o      (bank_en[b]),
      .max_o     (bank_max[b]),
      .cur_o     (bank_cur[b]),
      .req_o     (bank_req[b])
    );
  end

  logic [DW-1:0] rd_val, rdata_q;
  logic          bsel;
  assign bsel = region[0];

  always_comb begin
    rd_val = '0;
    unique case (region)
      REG_BANK0, REG_BANK1: begin
        unique case (int'(loc))
          OFF_STATUS:       rd_val = DW'(bank_status[bsel]);
          OFF_RAW:          rd_val = DW'(bank_raw[bsel]);
          OFF_EN:           rd_val = DW'(bank_en[bsel]);
          OFF_CUR, OFF_ACK: rd_val = DW'(bank_cur[bsel]);
          OFF_MAX:          rd_val = DW'(bank_max[bsel]);
          default:          rd_val = '0;
        endcase
      end
      REG_CFG: begin
        if (loc == LW'(OFF_POL))      rd_val = DW'(pol_q);
        else if (loc == LW'(OFF_STK)) rd_val = DW'(stk_q);
      end
      default: begin
        for (int i = 0; i < int'(N_SRC); i++)
          if (loc == LW'(i)) rd_val = DW'(prio_q[i]);
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_val;
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = bank_req[0];
  assign fiq_o       = bank_req[1];
endmodule

// File: rtl/intc_dual_bank_chk.sv
module intc_dual_bank_chk #(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned IDX_W = 5
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [DW-1:0]               bus_wdata_i,
  input logic                        stk_we,
  input logic [N_SRC-1:0]            stk_q,
  input logic [1:0]                  bank_en_set,
  input logic [1:0]                  bank_ack,
  input logic [1:0][N_SRC-1:0]       bank_status,
  input logic [1:0][N_SRC-1:0]       bank_raw,
  input logic [1:0][N_SRC-1:0]       bank_en,
  input logic [1:0][IDX_W-1:0]       bank_cur
);
  for (genvar b = 0; b < 2; b++) begin : g_b
    AST_CUR_IN_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bank_status[b] != '0) |-> bank_status[b][bank_cur[b]]); // R6
    AST_CUR_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bank_status[b] == '0) |-> (bank_cur[b] == '0)); // R6
    AST_STATUS_IN_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((bank_status[b] & ~bank_raw[b]) == '0)); // R5
    AST_STATUS_IN_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((bank_status[b] & ~bank_en[b]) == '0)); // R5
    AST_ENABLE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bank_en_set[b] |=> ((bank_en[b] & $past(bus_wdata_i[N_SRC-1:0])) == $past(bus_wdata_i[N_SRC-1:0]))); // R2
    AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!bank_ack[b] && !stk_we) |=> (($past(bank_raw[b] & stk_q) & ~bank_raw[b]) == '0)); // R4
  end
endmodule

bind intc_dual_bank intc_dual_bank_chk #(.N_SRC(N_SRC), .DW(DW), .IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_wdata_i(bus_wdata_i),
  .stk_we     (stk_we),
  .stk_q      (stk_q),
  .bank_en_set(bank_en_set),
  .bank_ack   (bank_ack),
  .bank_status(bank_status),
  .bank_raw   (bank_raw),
  .bank_en    (bank_en),
  .bank_cur   (bank_cur)
);

// File: tb/intc_dual_bank_tb.sv
module intc_dual_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_dual_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_addr_i(addr),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  // behavioural model
  logic [31:0] m_pol = '1, m_stk = '0, m_src = '0;
  logic [31:0] m_en [2];
  logic [31:0] m_lat [2];
  logic [3:0]  m_max [2];
  logic [3:0]  m_prio [32];
  logic        m_req [2];

  function automatic logic [31:0] m_cond();
    return ~(m_src ^ m_pol);
  endfunction
  function automatic logic [31:0] m_raw(input int b);
    return m_cond() | (m_lat[b] & m_stk);
  endfunction
  function automatic logic [31:0] m_elig(input int b);
    logic [31:0] r, e;
    r = m_raw(b);
    e = '0;
    for (int i = 0; i < 32; i++)
      e[i] = r[i] && m_en[b][i] && (m_prio[i] <= m_max[b]);
    return e;
  endfunction
  function automatic int m_win(input int b);
    logic [31:0] e;
    int best, w;
    e = m_elig(b);
    best = 16;
    w = 0;
    for (int i = 0; i < 32; i++)
      if (e[i] && int'(m_prio[i]) < best) begin best = int'(m_prio[i]); w = i; end
    return w;
  endfunction
  function automatic logic [31:0] m_read(input logic [7:0] a);
    int b, off;
    b = int'(a[6]);
    off = int'(a[5:0]);
    if (a[7] == 1'b0) begin
      case (off)
        'h00: return m_elig(b);
        'h01: return m_raw(b);
        'h02: return m_en[b];
        'h08, 'h0A: return 32'(m_win(b));
        'h0B: return {28'd0, m_max[b]};
        default: return '0;
      endcase
    end else if (a[6] == 1'b0) begin
      if (off == 0) return m_pol;
      if (off == 1) return m_stk;
      return '0;
    end
    return (off < 32) ? {28'd0, m_prio[off]} : '0;
  endfunction

  task automatic m_reset();
    m_pol = '1; m_stk = '0;
    for (int b = 0; b < 2; b++) begin
      m_en[b] = '0; m_lat[b] = '0; m_max[b] = 4'hF; m_req[b] = 1'b0;
    end
    for (int i = 0; i < 32; i++) m_prio[i] = '0;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ba(input int b, input int off);
    return 8'(b * 'h40 + off);
  endfunction

  // one bus cycle, called right after a negedge
  task automatic cyc(input logic [7:0] a, input logic r, input logic w,
                     input logic [31:0] d, input logic [31:0] s, input string tag);
    logic [31:0] exp_rd, nlat [2];
    logic        nreq [2];
    addr = a; rd = r; wr = w; wdata = d; src = s;
    m_src = s;
    exp_rd = m_read(a);
    for (int b = 0; b < 2; b++) begin
      logic [31:0] e, clr;
      e = m_elig(b);
      clr = (r && a[7] == 1'b0 && int'(a[6]) == b && a[5:0] == 6'h0A && e != 0)
            ? (32'd1 << m_win(b)) : '0;
      nlat[b] = ((m_lat[b] & ~clr) | m_cond()) & m_stk;
      nreq[b] = |e;
    end
    @(posedge clk);
    if (w) begin
      if (a[7] == 1'b0) begin
        if (a[5:0] == 6'h02) m_en[a[6]] = m_en[a[6]] | d;
        if (a[5:0] == 6'h03) m_en[a[6]] = m_en[a[6]] & ~d;
        if (a[5:0] == 6'h0B) m_max[a[6]] = d[3:0];
      end else if (a[6] == 1'b0) begin
        if (a[5:0] == 6'h00) m_pol = d;
        if (a[5:0] == 6'h01) m_stk = d;
      end else if (a[5:0] < 32) m_prio[a[5:0]] = d[3:0];
    end
    for (int b = 0; b < 2; b++) begin m_lat[b] = nlat[b]; m_req[b] = nreq[b]; end
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
    check("R9 irq", {31'd0, irq}, {31'd0, m_req[0]});
    check("R9 fiq", {31'd0, fiq}, {31'd0, m_req[1]});
    if (r) check({tag, " rdata R10"}, rdata, exp_rd);
  endtask

  task automatic rdr(input logic [7:0] a, input string tag);
    cyc(a, 1'b1, 1'b0, '0, m_src, tag);
  endtask
  task automatic wrr(input logic [7:0] a, input logic [31:0] d, input string tag);
    cyc(a, 1'b0, 1'b1, d, m_src, tag);
  endtask
  task automatic drv(input logic [31:0] s);
    cyc(8'h3F, 1'b0, 1'b0, '0, s, "idle");
  endtask

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values, also checked against constants
    rdr(ba(0, 'h02), "R1 en0");   check("R1 en0", rdata, 32'h0);
    rdr(ba(1, 'h0B), "R1 max1");  check("R1 max1", rdata, 32'hF);
    rdr(8'h80, "R1 pol");         check("R1 pol", rdata, 32'hFFFF_FFFF);
    rdr(8'h81, "R1 stk");
    rdr(8'hC5, "R1 prio5");
    rdr(ba(0, 'h08), "R1 cur");
    // R2 set/clear
    wrr(ba(0, 'h02), 32'h0000_00F0, "R2");
    wrr(ba(0, 'h03), 32'h0000_0030, "R2");
    rdr(ba(0, 'h02), "R2 en");    check("R2 en", rdata, 32'h0000_00C0);
    wrr(ba(0, 'h02), 32'h0, "R2");
    wrr(ba(0, 'h03), 32'h0, "R2");
    rdr(ba(0, 'h02), "R2 zero-write"); check("R2 zero-write", rdata, 32'h0000_00C0);
    wrr(ba(0, 'h03), 32'hFFFF_FFFF, "R2");
    // R3 polarity and raw
    drv(32'h0000_0001);
    rdr(ba(0, 'h01), "R3 raw");   check("R3 raw", rdata, 32'h0000_0001);
    wrr(8'h80, ~32'h2, "R3");
    rdr(ba(1, 'h01), "R3 inverted");  check("R3 inverted", rdata, 32'h0000_0003);
    wrr(8'h80, 32'hFFFF_FFFF, "R3");
    // R5 R6 R9 priority, ties, threshold
    wrr(ba(0, 'h02), 32'hFFFF_FFFF, "R5");
    wrr(8'hC7, 1, "R6"); wrr(8'hC3, 2, "R6"); wrr(8'hC9, 1, "R6");
    drv(32'h0000_0288);
    rdr(ba(0, 'h00), "R5 status");
    rdr(ba(0, 'h08), "R6 cur");   check("R6 tie", rdata, 32'd7);
    rdr(ba(1, 'h00), "R8 fiq status");
    wrr(ba(0, 'h0B), 0, "R5");
    rdr(ba(0, 'h00), "R5 threshold");  check("R5 threshold", rdata, 32'h0);
    rdr(ba(0, 'h08), "R6 idle");
    drv(32'h0000_0288);
    wrr(ba(0, 'h0B), 1, "R5");
    rdr(ba(0, 'h08), "R6 thr1");  check("R6 thr1", rdata, 32'd7);
    wrr(ba(0, 'h0B), 4'hF, "R5");
    drv(32'h0);
    // R4 R7 R8 sticky and acknowledge
    wrr(8'h81, 32'h0000_3000, "R4");
    wrr(ba(1, 'h02), 32'h0000_3000, "R8");
    drv(32'h0000_1000);
    drv(32'h0);
    rdr(ba(0, 'h01), "R4 latched");   check("R4 latched", rdata, 32'h0000_1000);
    rdr(ba(0, 'h0A), "R7 ack");       check("R7 ack", rdata, 32'd12);
    rdr(ba(0, 'h01), "R7 cleared");   check("R7 cleared", rdata, 32'h0);
    rdr(ba(1, 'h01), "R8 other bank"); check("R8 other bank", rdata, 32'h0000_1000);
    rdr(ba(0, 'h0A), "R7 empty ack");
    rdr(ba(1, 'h01), "R7 empty ack");
    // same cycle: ack fiq source 12 while source 13 rises
    cyc(ba(1, 'h0A), 1'b1, 1'b0, '0, 32'h0000_2000, "R7 ack+new");
    drv(32'h0);
    rdr(ba(1, 'h01), "R7 new survives"); check("R7 new survives", rdata, 32'h0000_2000);
    // ack while line still high re-latches
    drv(32'h0000_2000);
    cyc(ba(1, 'h0A), 1'b1, 1'b0, '0, 32'h0000_2000, "R7 held");
    drv(32'h0);
    rdr(ba(1, 'h08), "R4 relatch");   check("R4 relatch", rdata, 32'd13);
    rdr(ba(1, 'h0A), "R7 ack13");
    drv(32'h0);
    rdr(ba(1, 'h00), "R7 final");     check("R7 final", rdata, 32'h0);
    // R4 non-sticky follows level
    wrr(8'h81, 32'h0, "R4");
    drv(32'h0000_0040);
    drv(32'h0);
    rdr(ba(0, 'h01), "R4 level");     check("R4 level", rdata, 32'h0);
    rdr(8'hE0, "R10 unmapped");
    repeat (2) drv(32'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule